// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bus-facing half of a small byte-addressed nonvolatile memory. It watches the two-wire serial clock and data lines with a fast system clock and recognises start and stop conditions. It assembles bytes most significant bit first and answers each received byte with an acknowledge in the ninth clock slot. Read bytes go back to the master the same way. The data line is modelled only as an open-drain pull-down enable.

Everything that reaches the memory goes out as single-cycle strobes, and each strobe carries its payload:
- the decoded device-address byte, with its page bits and its read/write flag;
- the word-address byte;
- each write data byte;
- a request for the next read byte.

The memory-side controller owns the address pointer and the array. It reports an internal write cycle through a busy input. While that input is high the slave acknowledges nothing, so a master can poll for completion by retrying the device address.

Top module: `twi_mem_slave`

## Requirements
- R1: A falling data line while the clock is high is a start. It sends the engine to the device-address phase from any state, including mid-byte and mid-transfer, with the bit count restarted. A rising data line while the clock is high is a stop. It pulses `stop_stb` for one cycle, releases the data line and returns the engine to idle.
- R2: `sda_oe` changes only after a detected falling clock edge, so the slave never moves the data line while the clock is high.
- R3: The device-address byte is laid out as follows. Bit 0 is the direction: 1 means read. Bits [PAGE_W:1] are the page bits. Bits [7:PAGE_W+1] must equal `dev_id_i`. On a match the slave pulls the data line low for the ninth clock and pulses `cmd_stb`, with `cmd_rw` and `cmd_page` taken from the byte.
- R4: When the device-address byte does not match, the slave leaves the ninth clock high and issues no strobe. It then ignores every following byte until the next start.
- R5: In a write, the first byte after the device address is acknowledged and pulses `waddr_stb` with the byte on `wbyte`. Every later byte is acknowledged and pulses `wdata_stb` with the byte on `wbyte`.
- R6: While `busy_i` is high, no received byte is acknowledged and no address or data strobe is issued. The engine then stays silent until the next start.
- R7: After acknowledging a read device address, the slave pulses `rd_req`, captures `rd_data_i` in that same cycle and shifts it out MSB first, one bit per clock.
- R8: After each read byte the slave releases the line and samples the ninth clock. A low level means the master acknowledged: the slave sends the next byte, with a new `rd_req`. A high level means it did not: the slave drives nothing more and requests nothing more until a start.
- R9: All five strobes (`cmd_stb`, `waddr_stb`, `wdata_stb`, `rd_req`, `stop_stb`) last one cycle, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| dev_id_i | input | 7-PAGE_W | Device identity compared with the upper address bits |
| busy_i | input | 1 | Memory write cycle in progress |
| rd_data_i | input | 8 | Byte at the controller's current pointer |
| sda_oe | output | 1 | 1 pulls the data line low |
| cmd_stb | output | 1 | Device address accepted |
| cmd_rw | output | 1 | Direction bit of the accepted address |
| cmd_page | output | PAGE_W | Page bits of the accepted address |
| waddr_stb | output | 1 | Word-address byte valid on `wbyte` |
| wdata_stb | output | 1 | Write data byte valid on `wbyte` |
| wbyte | output | 8 | Received byte payload |
| rd_req | output | 1 | Read byte taken; controller advances its pointer |
| stop_stb | output | 1 | Stop condition seen |

## Verification
A wrong bit count or a wrong phase state shows up at the ports within one byte. The slave either acknowledges in the wrong clock slot, which the master sees as a missing or extra low on the ninth bit, or it emits a strobe of the wrong kind, which the event scoreboard catches in the cycle it appears. A stale read pointer or a wrongly shifted read byte appears as a bad value in the very next byte the master reads. A leftover state after a mismatch, a busy refusal or a master not-acknowledge appears as an acknowledge or a strobe on the following byte.

// File: rtl/twi_pkg.sv
package twi_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_WADR,
      ST_WDAT,
      ST_TX
   } twi_st_e;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q,
   output logic q_prev,
   output logic rise,
   output logic fall
);

   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("twi_line_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain  <= {STAGES{RST_VAL}};
         q_prev <= RST_VAL;
      end else begin
         chain  <= {chain[STAGES-2:0], d};
         q_prev <= chain[STAGES-1];
      end
   end

   assign q    = chain[STAGES-1];
   assign rise = q & ~q_prev;
   assign fall = ~q & q_prev;

endmodule

// File: rtl/twi_cond_det.sv
module twi_cond_det (
   input  logic scl_q,
   input  logic scl_p,
   input  logic sda_q,
   input  logic sda_p,
   output logic start_c,
   output logic stop_c
);

   logic clk_high;

   assign clk_high = scl_q & scl_p;
   assign start_c  = clk_high & sda_p & ~sda_q;
   assign stop_c   = clk_high & ~sda_p & sda_q;

endmodule

// File: rtl/twi_shifter.sv
module twi_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         rise,
   input  logic         fall,
   input  logic         din,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] q,
   output logic         at_byte,
   output logic         at_slot,
   output logic         cnt_nz
);

   localparam int CW = $clog2(W + 2);
   localparam logic [CW-1:0] C_BYTE = CW'(W);
   localparam logic [CW-1:0] C_SLOT = CW'(W + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q   <= '0;
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else begin
         if (load) begin
            q <= load_val;
         end else if (rise && (cnt < C_BYTE)) begin
            q <= {q[W-2:0], din};
         end
         if (rise && (cnt < C_SLOT)) begin
            cnt <= cnt + 1'b1;
         end else if (fall && (cnt == C_SLOT)) begin
            cnt <= '0;
         end
      end
   end

   assign at_byte = (cnt == C_BYTE);
   assign at_slot = (cnt == C_SLOT);
   assign cnt_nz  = (cnt != '0);

endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave #(
   parameter int PAGE_W      = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         scl_i,
   input  logic                         sda_i,
   input  logic [6-PAGE_W:0]            dev_id_i,
   input  logic                         busy_i,
   input  logic [twi_pkg::BYTE_W-1:0]   rd_data_i,
   output logic                         sda_oe,
   output logic                         cmd_stb,
   output logic                         cmd_rw,
   output logic [PAGE_W-1:0]            cmd_page,
   output logic                         waddr_stb,
   output logic                         wdata_stb,
   output logic [twi_pkg::BYTE_W-1:0]   wbyte,
   output logic                         rd_req,
   output logic                         stop_stb
);

   import twi_pkg::*;

   localparam int BW   = BYTE_W;
   localparam int ID_W = 7 - PAGE_W;
   localparam int N_LN = 2;
   localparam int L_SCL = 0;
   localparam int L_SDA = 1;

   generate
      if (PAGE_W < 1 || PAGE_W > 3) begin : g_bad_page
         $error("twi_mem_slave: PAGE_W must be 1..3");
      end
   endgenerate

   // line synchronizers
   logic [N_LN-1:0] ln_raw, ln_q, ln_p, ln_r, ln_f;
   assign ln_raw = {sda_i, scl_i};

   generate
      for (genvar i = 0; i < N_LN; i++) begin : g_line
         twi_line_sync #(
            .STAGES (SYNC_STAGES),
            .RST_VAL(1'b1)
         ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (ln_raw[i]),
            .q     (ln_q[i]),
            .q_prev(ln_p[i]),
            .rise  (ln_r[i]),
            .fall  (ln_f[i])
         );
      end
   endgenerate

   logic scl_r, scl_f, sda_q;
   assign scl_r = ln_r[L_SCL];
   assign scl_f = ln_f[L_SCL];
   assign sda_q = ln_q[L_SDA];

   logic start_c, stop_c;

   twi_cond_det u_cond (
      .scl_q  (ln_q[L_SCL]),
      .scl_p  (ln_p[L_SCL]),
      .sda_q  (ln_q[L_SDA]),
      .sda_p  (ln_p[L_SDA]),
      .start_c(start_c),
      .stop_c (stop_c)
   );

   // state
   twi_st_e st, nxt;
   logic    m_ack;

   logic          tx_load;
   logic [BW-1:0] sh_q;
   logic          at_byte, at_slot, cnt_nz;
   logic          rx_st, rx_ok, id_hit, bus_evt;

   assign bus_evt = start_c | stop_c;
   assign rx_st   = (st == ST_DEV) || (st == ST_WADR) || (st == ST_WDAT);
   assign id_hit  = (sh_q[BW-1 -: ID_W] == dev_id_i);
   assign rx_ok   = !busy_i && ((st != ST_DEV) || id_hit);

   always_comb begin
      tx_load = 1'b0;
      if (!bus_evt && scl_f && at_slot) begin
         if (rx_st && (nxt == ST_TX)) tx_load = 1'b1;
         if ((st == ST_TX) && m_ack)  tx_load = 1'b1;
      end
   end

   twi_shifter #(
      .W(BW)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (start_c),
      .rise    (scl_r),
      .fall    (scl_f),
      .din     (sda_q),
      .load    (tx_load),
      .load_val(rd_data_i),
      .q       (sh_q),
      .at_byte (at_byte),
      .at_slot (at_slot),
      .cnt_nz  (cnt_nz)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         nxt       <= ST_IDLE;
         m_ack     <= 1'b0;
         sda_oe    <= 1'b0;
         cmd_stb   <= 1'b0;
         cmd_rw    <= 1'b0;
         cmd_page  <= '0;
         waddr_stb <= 1'b0;
         wdata_stb <= 1'b0;
         wbyte     <= '0;
         rd_req    <= 1'b0;
         stop_stb  <= 1'b0;
      end else begin
         cmd_stb   <= 1'b0;
         waddr_stb <= 1'b0;
         wdata_stb <= 1'b0;
         rd_req    <= 1'b0;
         stop_stb  <= 1'b0;
         if (start_c) begin
            st     <= ST_DEV;
            sda_oe <= 1'b0;
         end else if (stop_c) begin
            st       <= ST_IDLE;
            sda_oe   <= 1'b0;
            stop_stb <= 1'b1;
         end else begin
            if (scl_r && at_byte && (st == ST_TX)) begin
               m_ack <= ~sda_q;
            end
            if (scl_f) begin
               if (tx_load) begin
                  st     <= ST_TX;
                  rd_req <= 1'b1;
                  sda_oe <= ~rd_data_i[BW-1];
               end else if (rx_st) begin
                  if (at_byte) begin
                     if (rx_ok) begin
                        sda_oe <= 1'b1;
                        case (st)
                           ST_DEV: begin
                              cmd_stb  <= 1'b1;
                              cmd_rw   <= sh_q[0];
                              cmd_page <= sh_q[PAGE_W:1];
                              nxt      <= sh_q[0] ? ST_TX : ST_WADR;
                           end
                           ST_WADR: begin
                              waddr_stb <= 1'b1;
                              wbyte     <= sh_q;
                              nxt       <= ST_WDAT;
                           end
                           default: begin
                              wdata_stb <= 1'b1;
                              wbyte     <= sh_q;
                              nxt       <= ST_WDAT;
                           end
                        endcase
                     end else begin
                        st     <= ST_IDLE;
                        sda_oe <= 1'b0;
                     end
                  end else if (at_slot) begin
                     sda_oe <= 1'b0;
                     st     <= nxt;
                  end
               end else if (st == ST_TX) begin
                  if (at_slot) begin
                     st     <= ST_IDLE;
                     sda_oe <= 1'b0;
                  end else if (at_byte) begin
                     sda_oe <= 1'b0;
                  end else if (cnt_nz) begin
                     sda_oe <= ~sh_q[BW-1];
                  end
               end else begin
                  sda_oe <= 1'b0;
               end
            end
         end
      end
   end

endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_i,
   input logic busy_i,
   input logic sda_oe,
   input logic cmd_stb,
   input logic waddr_stb,
   input logic wdata_stb,
   input logic rd_req,
   input logic stop_stb
);

   // R2: data line drive moves only while the clock is low
   p_oe_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !scl_i);

   // R6: no acceptance strobe follows a busy cycle
   p_busy_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |=> !(cmd_stb || waddr_stb || wdata_stb));

   // R1: stop leaves the line released
   p_stop_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
      stop_stb |-> !sda_oe);

   // R9: strobes never overlap
   p_strobe_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_stb, waddr_stb, wdata_stb, rd_req, stop_stb}));

   // R9: strobes last a single cycle
   p_rd_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> !rd_req);

   p_wdata_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wdata_stb |=> !wdata_stb);

endmodule

bind twi_mem_slave twi_mem_slave_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_i    (scl_i),
   .busy_i   (busy_i),
   .sda_oe   (sda_oe),
   .cmd_stb  (cmd_stb),
   .waddr_stb(waddr_stb),
   .wdata_stb(wdata_stb),
   .rd_req   (rd_req),
   .stop_stb (stop_stb)
);

// File: tb/sim_twi_mem_slave.sv
`timescale 1ns/1ps
module sim_twi_mem_slave;

   localparam int PW = 2;
   localparam int Q  = 20;
   localparam logic [4:0] MY_ID = 5'b10100;

   localparam logic [3:0] K_CMD = 4'd1, K_WADR = 4'd2, K_WDAT = 4'd3,
                          K_RD  = 4'd4, K_STOP = 4'd5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic m_scl = 1'b1, m_sda = 1'b1;
   logic busy = 1'b0;
   logic [7:0] rd_data;
   logic sda_oe, cmd_stb, cmd_rw, waddr_stb, wdata_stb, rd_req, stop_stb;
   logic [PW-1:0] cmd_page;
   logic [7:0] wbyte;
   wire  sda_line = m_sda & ~sda_oe;

   always #5 clk = ~clk;

   twi_mem_slave #(.PAGE_W(PW), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
      .dev_id_i(MY_ID), .busy_i(busy), .rd_data_i(rd_data),
      .sda_oe(sda_oe), .cmd_stb(cmd_stb), .cmd_rw(cmd_rw), .cmd_page(cmd_page),
      .waddr_stb(waddr_stb), .wdata_stb(wdata_stb), .wbyte(wbyte),
      .rd_req(rd_req), .stop_stb(stop_stb)
   );

   int total = 0, bad = 0, r2_bad = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // memory-side controller model
   logic [7:0]      mem [1024];
   logic [PW+7:0]   ptr = '0;
   logic [PW-1:0]   pg  = '0;

   function automatic logic [7:0] pat(input int a);
      return 8'(a) ^ 8'h5A ^ 8'(a >> 8);
   endfunction

   initial for (int i = 0; i < 1024; i++) mem[i] = pat(i);

   assign rd_data = mem[ptr];

   always @(posedge clk) begin
      if (cmd_stb && !cmd_rw) pg <= cmd_page;
      if (waddr_stb) ptr <= {pg, wbyte};
      if (wdata_stb) begin
         mem[ptr] <= wbyte;
         ptr <= ptr + 1'b1;
      end
      if (rd_req) ptr <= ptr + 1'b1;
   end

   // scoreboard
   logic [15:0] expq [$];
   logic [15:0] got_ev, want_ev;
   int          n_stb;

   task automatic push_ev(input logic [3:0] k, input logic [7:0] d);
      expq.push_back({k, 4'd0, d});
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         n_stb = int'(cmd_stb) + int'(waddr_stb) + int'(wdata_stb) + int'(rd_req) + int'(stop_stb);
         if (n_stb > 1) chk(1'b0, "R9 overlap", n_stb, 1);
         if (n_stb != 0) begin
            if (cmd_stb)        got_ev = {K_CMD, 4'd0, 5'd0, cmd_page, cmd_rw};
            else if (waddr_stb) got_ev = {K_WADR, 4'd0, wbyte};
            else if (wdata_stb) got_ev = {K_WDAT, 4'd0, wbyte};
            else if (rd_req)    got_ev = {K_RD, 12'd0};
            else                got_ev = {K_STOP, 12'd0};
            if (expq.size() == 0) begin
               chk(1'b0, "R9 unexpected strobe", int'(got_ev), 0);
            end else begin
               want_ev = expq.pop_front();
               chk(got_ev == want_ev, "R5/R7 strobe event", int'(got_ev), int'(want_ev));
            end
         end
      end
   end

   // R2 watcher: drive must not move while clock is high
   logic oe_d = 1'b0, scl_d = 1'b1;
   always @(negedge clk) begin
      if (rst_n && m_scl && scl_d && (sda_oe != oe_d)) r2_bad++;
      oe_d  <= sda_oe;
      scl_d <= m_scl;
   end

   // master bus tasks
   task automatic wq; repeat (Q) @(posedge clk); endtask

   task automatic bus_start;
      m_sda = 1'b1; wq; m_scl = 1'b1; wq; m_sda = 1'b0; wq; m_scl = 1'b0; wq;
   endtask

   task automatic bus_stop;
      m_sda = 1'b0; wq; m_scl = 1'b1; wq; m_sda = 1'b1; wq;
   endtask

   task automatic clk_bit(input logic b, output logic s);
      m_sda = b; wq; m_scl = 1'b1; wq; s = sda_line; wq; m_scl = 1'b0; wq;
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
      clk_bit(1'b1, s);
      ack = ~s;
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] d);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b1, s);
         d[i] = s;
      end
      clk_bit(~give_ack, s);
   endtask

   function automatic logic [7:0] adr(input logic [4:0] id, input logic [PW-1:0] p, input logic rw);
      return {id, p, rw};
   endfunction

   task automatic q_empty(input string req);
      wq;
      chk(expq.size() == 0, req, expq.size(), 0);
      expq.delete();
   endtask

   task automatic run_all;
      logic ack, s;
      logic [7:0] d;

      // reset state
      chk(sda_oe == 1'b0, "R1 reset release", sda_oe, 0);
      chk({cmd_stb, waddr_stb, wdata_stb, rd_req, stop_stb} == 5'd0, "R9 reset strobes",
          {cmd_stb, waddr_stb, wdata_stb, rd_req, stop_stb}, 0);

      // write: address page 1, word 0x10, two bytes
      push_ev(K_CMD, 8'h02); push_ev(K_WADR, 8'h10);
      push_ev(K_WDAT, 8'hA5); push_ev(K_WDAT, 8'h3C); push_ev(K_STOP, 8'h00);
      bus_start;
      send_byte(adr(MY_ID, 2'd1, 1'b0), ack); chk(ack, "R3 address ack", ack, 1);
      send_byte(8'h10, ack); chk(ack, "R5 word address ack", ack, 1);
      send_byte(8'hA5, ack); chk(ack, "R5 data ack", ack, 1);
      send_byte(8'h3C, ack); chk(ack, "R5 second data ack", ack, 1);
      bus_stop;
      q_empty("R5 write events");

      // random read through repeated start
      push_ev(K_CMD, 8'h02); push_ev(K_WADR, 8'h10);
      push_ev(K_CMD, 8'h03); push_ev(K_RD, 8'h00); push_ev(K_RD, 8'h00);
      push_ev(K_STOP, 8'h00);
      bus_start;
      send_byte(adr(MY_ID, 2'd1, 1'b0), ack); chk(ack, "R3 address ack", ack, 1);
      send_byte(8'h10, ack); chk(ack, "R5 word address ack", ack, 1);
      bus_start;
      send_byte(adr(MY_ID, 2'd1, 1'b1), ack); chk(ack, "R3 read address ack", ack, 1);
      recv_byte(1'b1, d); chk(d == 8'hA5, "R7 first read byte", d, 8'hA5);
      recv_byte(1'b0, d); chk(d == 8'h3C, "R8 byte after master ack", d, 8'h3C);
      recv_byte(1'b0, d); chk(d == 8'hFF, "R8 silent after master nack", d, 8'hFF);
      bus_stop;
      q_empty("R8 read events");

      // current address read
      push_ev(K_CMD, 8'h03); push_ev(K_RD, 8'h00); push_ev(K_STOP, 8'h00);
      bus_start;
      send_byte(adr(MY_ID, 2'd1, 1'b1), ack); chk(ack, "R3 read address ack", ack, 1);
      recv_byte(1'b0, d); chk(d == pat(12'h112), "R7 current address byte", d, pat(12'h112));
      bus_stop;
      q_empty("R7 current read events");

      // identity mismatch
      push_ev(K_STOP, 8'h00);
      bus_start;
      send_byte(adr(5'b10101, 2'd0, 1'b0), ack); chk(!ack, "R4 mismatch nack", ack, 0);
      send_byte(8'h55, ack); chk(!ack, "R4 following byte ignored", ack, 0);
      bus_stop;
      q_empty("R4 no strobes");

      // busy at device address
      push_ev(K_STOP, 8'h00);
      busy = 1'b1;
      bus_start;
      send_byte(adr(MY_ID, 2'd0, 1'b0), ack); chk(!ack, "R6 busy address nack", ack, 0);
      bus_stop;
      busy = 1'b0;
      q_empty("R6 busy address events");

      // busy during data
      push_ev(K_CMD, 8'h00); push_ev(K_WADR, 8'h20); push_ev(K_STOP, 8'h00);
      bus_start;
      send_byte(adr(MY_ID, 2'd0, 1'b0), ack); chk(ack, "R3 address ack", ack, 1);
      send_byte(8'h20, ack); chk(ack, "R5 word address ack", ack, 1);
      busy = 1'b1;
      send_byte(8'h77, ack); chk(!ack, "R6 busy data nack", ack, 0);
      busy = 1'b0;
      send_byte(8'h66, ack); chk(!ack, "R6 silent until start", ack, 0);
      bus_stop;
      q_empty("R6 busy data events");

      // repeated start in the middle of a byte
      push_ev(K_CMD, 8'h00); push_ev(K_CMD, 8'h05); push_ev(K_RD, 8'h00);
      push_ev(K_STOP, 8'h00);
      bus_start;
      send_byte(adr(MY_ID, 2'd0, 1'b0), ack); chk(ack, "R3 address ack", ack, 1);
      for (int i = 0; i < 4; i++) clk_bit(1'b1, s);
      bus_start;
      send_byte(adr(MY_ID, 2'd2, 1'b1), ack); chk(ack, "R1 restart realigns address", ack, 1);
      recv_byte(1'b0, d); chk(d == pat(12'h020), "R1 read after restart", d, pat(12'h020));
      bus_stop;
      q_empty("R1 restart events");

      chk(r2_bad == 0, "R2 drive stable while clock high", r2_bad, 0);
   endtask

   initial begin
      bit timed_out;
      timed_out = 1'b0;
      repeat (5) @(posedge clk);
      rst_n = 1'b1;
      repeat (5) @(posedge clk);
      fork
         run_all;
         begin
            repeat (190000) @(posedge clk);
            timed_out = 1'b1;
         end
      join_any
      disable fork;
      if (timed_out) chk(1'b0, "watchdog", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule